// File: doc/BRIEF.md
# Parallel Display Bus Command Controller

This block lets a processor drive one or two display-controller chips that hang on a shared 16-bit parallel bus. Software writes command words, parameter words and pixel data into a small register window. Each such write becomes one or two bus cycles. On every cycle the block drives a command/data select line, the chip selects of the chips that are targeted, and a write or read strobe. A 32-bit register port with a ready handshake stalls the processor until the bus cycles of its access have finished.

Two bits of the control register select the chips that each access targets. A pixel counter, loaded by software, counts down on every pixel-data write and on every bus read. A transfer is started by writing the trigger bit of the control register, and it ends when the counter runs out. At that point the busy flag drops and the block emits a one-cycle frame-done pulse, which a neighbouring interrupt block records as its status bit 0. Bus timing programming, memory fetch of the framebuffer and the bypass path are not part of this block.

Top module: `fbbus_ctrl`

## Requirements
- R1: After reset the control register reads 0x2, both configuration registers read 0x00310000, the pixel counter reads 0, and the system status register reads 0x1.
- R2: The control register keeps only bits 3:0. The line-skip register keeps 11 bits and each sync width register keeps 16 bits. Each configuration register keeps only the bits in mask 0x003F1FFF.
- R3: A write to the command address (word 4) sends bits 15:0 in one bus cycle with the select line low. A write to the parameter address (word 5) does the same with the select line high. In both cases the chip selects of every targeted chip are driven low together: control bit 2 targets chip 0 (cs_n[0]) and control bit 3 targets chip 1 (cs_n[1]).
- R4: A write to the pixel-data address (word 6) sends two bus cycles with the select line high to every targeted chip: bits 15:0 first, then bits 31:16.
- R5: A write to the data-read address (word 7, select high) or to the status-read address (word 8, select low) runs one read cycle. That cycle goes to chip 0 if chip 0 is targeted, otherwise to chip 1, and the returned 16 bits are latched into a receive buffer. A register read of word 7 or word 8 returns that buffer. With no chip targeted, the buffer is left unchanged.
- R6: Each bus cycle holds one strobe and its chip selects low for exactly one clock. The register port holds ready low from the start of the access until all of its cycles are done, so an access waits one clock more than its number of bus cycles. An access with no chip targeted runs no bus cycle.
- R7: Each pixel-data write, data read and status read decrements the pixel counter, whether or not a chip is targeted. If the counter is already zero it stays zero and busy stays low.
- R8: A control write with bit 4 set starts a transfer and sets busy (status bit 8) only when all of these hold: bit 0 of the written value is 1, bit 1 of the written value is 0, the block is not busy, and bits 3:2 are not set in both configuration registers at once.
- R9: When a decrement takes the counter of a busy transfer to zero, busy clears and frame_done pulses for one clock. A transfer started with the counter at zero completes at once with one frame_done pulse and no busy.
- R10: The system status register (word 0) reads bit 0 = 1 and bit 8 = busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_req | input | 1 | Register access request, held until ready |
| reg_wr | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 5 | Register word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid while ready |
| reg_ready | output | 1 | Access completes on a clock edge where request and ready are both high |
| bus_wdata | output | 16 | Bus write data |
| bus_rdata | input | 16 | Bus read data, sampled at the end of a read cycle |
| bus_dc | output | 1 | Select line: 0 = command/status, 1 = data/parameter |
| bus_cs_n | output | 2 | Active-low chip selects, bit 0 for chip 0 |
| bus_wr_n | output | 1 | Active-low write strobe |
| bus_rd_n | output | 1 | Active-low read strobe |
| frame_done | output | 1 | One-clock pulse when a triggered transfer ends |

## Verification
Assertions check the bus on every cycle. They check that the two strobes are never low together, that a strobe only goes out with a chip selected, that a read selects exactly one chip, and that ready stays low while a strobe is active. They also check that the pixel counter never wraps below zero, that busy rises only with a non-zero count, and that busy falls only together with a frame-done pulse. The bench's scenarios cover the rest. These are the data words and their order on the bus, the chip-priority rule for reads, the register field masks, each condition that blocks a trigger, and the exact number of wait cycles per access.

// File: rtl/fbb_pkg.sv
package fbb_pkg;
  localparam int ADDR_W = 5;
  localparam int WORD_W = 32;

  typedef enum logic [2:0] {
    OP_CMD,
    OP_PARAM,
    OP_DATA,
    OP_RXD,
    OP_RXS
  } bus_op_e;

  localparam logic [ADDR_W-1:0] A_STAT  = 5'd0;
  localparam logic [ADDR_W-1:0] A_CTRL  = 5'd1;
  localparam logic [ADDR_W-1:0] A_PIX   = 5'd2;
  localparam logic [ADDR_W-1:0] A_SKIP  = 5'd3;
  localparam logic [ADDR_W-1:0] A_CMD   = 5'd4;
  localparam logic [ADDR_W-1:0] A_PARAM = 5'd5;
  localparam logic [ADDR_W-1:0] A_DATA  = 5'd6;
  localparam logic [ADDR_W-1:0] A_RXD   = 5'd7;
  localparam logic [ADDR_W-1:0] A_RXS   = 5'd8;
  localparam logic [ADDR_W-1:0] A_CFG0  = 5'd9;
  localparam logic [ADDR_W-1:0] A_CFG1  = 5'd10;
  localparam logic [ADDR_W-1:0] A_VSW   = 5'd11;
  localparam logic [ADDR_W-1:0] A_HSW   = 5'd12;

  localparam logic [WORD_W-1:0] CFG_RST  = 32'h0031_0000;
  localparam logic [WORD_W-1:0] CFG_MASK = 32'h003F_1FFF;
  localparam logic [WORD_W-1:0] CFG_BOTH = 32'h0000_000C;
  localparam logic [3:0]        CTRL_RST = 4'h2;
endpackage

// File: rtl/fbb_seq.sv
module fbb_seq
  import fbb_pkg::*;
#(
  parameter int BUS_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  bus_op_e            op_i,
  input  logic [2*BUS_W-1:0] word_i,
  input  logic [1:0]         tgt_i,
  input  logic [BUS_W-1:0]   bus_rdata,
  output logic [BUS_W-1:0]   bus_wdata,
  output logic               bus_dc,
  output logic [1:0]         bus_cs_n,
  output logic               bus_wr_n,
  output logic               bus_rd_n,
  output logic               done_o,
  output logic               idle_o,
  output logic [BUS_W-1:0]   rx_o
);
  typedef enum logic [1:0] {S_IDLE, S_BUS, S_FIN} seq_st_e;

  seq_st_e            st_q, st_d;
  bus_op_e            op_q, op_d;
  logic               ph_q, ph_d;
  logic [1:0]         msk_q, msk_d;
  logic [2*BUS_W-1:0] word_q, word_d;
  logic               dc_q, dc_d;
  logic [BUS_W-1:0]   rx_q, rx_d;
  logic               rd_q, rd_i;

  assign rd_q = (op_q == OP_RXD) || (op_q == OP_RXS);
  assign rd_i = (op_i == OP_RXD) || (op_i == OP_RXS);

  // next state
  always_comb begin
    st_d   = st_q;
    op_d   = op_q;
    ph_d   = ph_q;
    msk_d  = msk_q;
    word_d = word_q;
    dc_d   = dc_q;
    rx_d   = rx_q;
    case (st_q)
      S_IDLE: begin
        if (start) begin
          op_d   = op_i;
          word_d = word_i;
          ph_d   = 1'b0;
          dc_d   = !((op_i == OP_CMD) || (op_i == OP_RXS));
          if (rd_i) begin
            // chip 0 wins when both are targeted
            if (tgt_i[0])      msk_d = 2'b01;
            else if (tgt_i[1]) msk_d = 2'b10;
            else               msk_d = 2'b00;
          end else begin
            msk_d = tgt_i;
          end
          st_d = (msk_d == 2'b00) ? S_FIN : S_BUS;
        end
      end
      S_BUS: begin
        if (rd_q) rx_d = bus_rdata;
        if ((op_q == OP_DATA) && !ph_q) ph_d = 1'b1;
        else                            st_d = S_FIN;
      end
      default: st_d = S_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= S_IDLE;
      op_q   <= OP_CMD;
      ph_q   <= 1'b0;
      msk_q  <= 2'b00;
      word_q <= '0;
      dc_q   <= 1'b0;
      rx_q   <= '0;
    end else begin
      st_q   <= st_d;
      op_q   <= op_d;
      ph_q   <= ph_d;
      msk_q  <= msk_d;
      word_q <= word_d;
      dc_q   <= dc_d;
      rx_q   <= rx_d;
    end
  end

  assign bus_cs_n  = (st_q == S_BUS) ? ~msk_q : 2'b11;
  assign bus_wr_n  = !((st_q == S_BUS) && !rd_q);
  assign bus_rd_n  = !((st_q == S_BUS) && rd_q);
  assign bus_dc    = dc_q;
  assign bus_wdata = ph_q ? word_q[2*BUS_W-1:BUS_W] : word_q[BUS_W-1:0];
  assign done_o    = (st_q == S_FIN);
  assign idle_o    = (st_q == S_IDLE);
  assign rx_o      = rx_q;

  a_r6_strobe_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(!bus_wr_n && !bus_rd_n));
  a_r6_strobe_has_cs: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_wr_n || !bus_rd_n) |-> (bus_cs_n != 2'b11));
  a_r5_read_one_chip: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd_n |-> ($countones(~bus_cs_n) == 1));
  a_r4_second_half: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_wr_n && (op_q == OP_DATA) && !ph_q) |=> (!bus_wr_n && ph_q));
endmodule

// File: rtl/fbb_regs.sv
module fbb_regs
  import fbb_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int SKIP_W = 11,
  parameter int SYNC_W = 16,
  parameter int BUS_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [WORD_W-1:0] wdata,
  input  logic              cnt_fire,
  input  logic [BUS_W-1:0]  rxbuf,
  output logic [WORD_W-1:0] rdata,
  output logic [1:0]        tgt_o,
  output logic              busy_o,
  output logic              done_o
);
  logic [3:0]        ctrl_q, ctrl_d;
  logic [CNT_W-1:0]  pix_q, pix_d;
  logic [SKIP_W-1:0] skip_q, skip_d;
  logic [WORD_W-1:0] cfg0_q, cfg0_d, cfg1_q, cfg1_d;
  logic [SYNC_W-1:0] vsw_q, vsw_d, hsw_q, hsw_d;
  logic              busy_q, busy_d, done_q, done_d;
  logic              trig_ok;

  assign trig_ok = wr_en && (addr == A_CTRL) && wdata[4] && wdata[0] && !wdata[1]
                   && !busy_q && ((cfg0_q & cfg1_q & CFG_BOTH) == '0);

  always_comb begin
    ctrl_d = ctrl_q;
    pix_d  = pix_q;
    skip_d = skip_q;
    cfg0_d = cfg0_q;
    cfg1_d = cfg1_q;
    vsw_d  = vsw_q;
    hsw_d  = hsw_q;
    busy_d = busy_q;
    done_d = 1'b0;
    if (wr_en) begin
      case (addr)
        A_CTRL: ctrl_d = wdata[3:0];
        A_PIX:  pix_d  = wdata[CNT_W-1:0];
        A_SKIP: skip_d = wdata[SKIP_W-1:0];
        A_CFG0: cfg0_d = wdata & CFG_MASK;
        A_CFG1: cfg1_d = wdata & CFG_MASK;
        A_VSW:  vsw_d  = wdata[SYNC_W-1:0];
        A_HSW:  hsw_d  = wdata[SYNC_W-1:0];
        default: ;
      endcase
    end
    if (trig_ok) begin
      if (pix_q != '0) busy_d = 1'b1;
      else             done_d = 1'b1;
    end
    if (cnt_fire) begin
      if (pix_q != '0) pix_d = pix_q - 1'b1;
      if (busy_q && (pix_q <= CNT_W'(1))) begin
        busy_d = 1'b0;
        done_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= CTRL_RST;
      pix_q  <= '0;
      skip_q <= '0;
      cfg0_q <= CFG_RST;
      cfg1_q <= CFG_RST;
      vsw_q  <= '0;
      hsw_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      ctrl_q <= ctrl_d;
      pix_q  <= pix_d;
      skip_q <= skip_d;
      cfg0_q <= cfg0_d;
      cfg1_q <= cfg1_d;
      vsw_q  <= vsw_d;
      hsw_q  <= hsw_d;
      busy_q <= busy_d;
      done_q <= done_d;
    end
  end

  always_comb begin
    rdata = '0;
    case (addr)
      A_STAT:        rdata = {23'd0, busy_q, 7'd0, 1'b1};
      A_CTRL:        rdata = WORD_W'(ctrl_q);
      A_PIX:         rdata = WORD_W'(pix_q);
      A_SKIP:        rdata = WORD_W'(skip_q);
      A_RXD, A_RXS:  rdata = WORD_W'(rxbuf);
      A_CFG0:        rdata = cfg0_q;
      A_CFG1:        rdata = cfg1_q;
      A_VSW:         rdata = WORD_W'(vsw_q);
      A_HSW:         rdata = WORD_W'(hsw_q);
      default:       rdata = '0;
    endcase
  end

  assign tgt_o  = ctrl_q[3:2];
  assign busy_o = busy_q;
  assign done_o = done_q;

  a_r7_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_fire && (pix_q == '0)) |=> (pix_q == '0));
  a_r8_busy_needs_count: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_q) |-> (pix_q != '0));
  a_r9_busy_fall_done: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_q) |-> done_q);
  a_r7_busy_idle_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && cnt_fire && (pix_q == CNT_W'(1))) |=> (!busy_q && (pix_q == '0)));
endmodule

// File: rtl/fbbus_ctrl.sv
module fbbus_ctrl
  import fbb_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int SKIP_W = 11,
  parameter int SYNC_W = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_req,
  input  logic        reg_wr,
  input  logic [4:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        reg_ready,
  output logic [15:0] bus_wdata,
  input  logic [15:0] bus_rdata,
  output logic        bus_dc,
  output logic [1:0]  bus_cs_n,
  output logic        bus_wr_n,
  output logic        bus_rd_n,
  output logic        frame_done
);
  localparam int BUS_W = WORD_W / 2;

  // asynchronous assert, synchronous release
  logic [1:0] rsync_q;
  logic       rst_q_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_q_n = rsync_q[1];

  bus_op_e          op;
  logic             is_bus, bus_acc, seq_done, seq_idle, start, cnt_fire, wr_en;
  logic [1:0]       tgt;
  logic [BUS_W-1:0] rxbuf;

  always_comb begin
    is_bus = 1'b1;
    op     = OP_CMD;
    case (reg_addr)
      A_CMD:   op = OP_CMD;
      A_PARAM: op = OP_PARAM;
      A_DATA:  op = OP_DATA;
      A_RXD:   op = OP_RXD;
      A_RXS:   op = OP_RXS;
      default: is_bus = 1'b0;
    endcase
  end

  assign bus_acc   = reg_req && reg_wr && is_bus;
  assign start     = bus_acc && seq_idle;
  assign reg_ready = !bus_acc || seq_done;
  assign wr_en     = reg_req && reg_wr && !is_bus;
  assign cnt_fire  = bus_acc && seq_done && (op != OP_CMD) && (op != OP_PARAM);

  fbb_seq #(.BUS_W(BUS_W)) u_seq (
    .clk       (clk),
    .rst_n     (rst_q_n),
    .start     (start),
    .op_i      (op),
    .word_i    (reg_wdata),
    .tgt_i     (tgt),
    .bus_rdata (bus_rdata),
    .bus_wdata (bus_wdata),
    .bus_dc    (bus_dc),
    .bus_cs_n  (bus_cs_n),
    .bus_wr_n  (bus_wr_n),
    .bus_rd_n  (bus_rd_n),
    .done_o    (seq_done),
    .idle_o    (seq_idle),
    .rx_o      (rxbuf)
  );

  fbb_regs #(
    .CNT_W (CNT_W),
    .SKIP_W(SKIP_W),
    .SYNC_W(SYNC_W),
    .BUS_W (BUS_W)
  ) u_regs (
    .clk      (clk),
    .rst_n    (rst_q_n),
    .wr_en    (wr_en),
    .addr     (reg_addr),
    .wdata    (reg_wdata),
    .cnt_fire (cnt_fire),
    .rxbuf    (rxbuf),
    .rdata    (reg_rdata),
    .tgt_o    (tgt),
    .busy_o   (),
    .done_o   (frame_done)
  );

  a_r6_stall_during_cycle: assert property (@(posedge clk) disable iff (!rst_q_n)
    (!bus_wr_n || !bus_rd_n) |-> !reg_ready);
endmodule

// File: tb/fbbus_ctrl_tb_top.sv
`timescale 1ns/1ps
module fbbus_ctrl_tb_top;
  localparam logic [4:0] AD_STAT = 5'd0, AD_CTRL = 5'd1, AD_PIX = 5'd2, AD_SKIP = 5'd3,
                         AD_CMD = 5'd4, AD_PARAM = 5'd5, AD_DATA = 5'd6, AD_RXD = 5'd7,
                         AD_RXS = 5'd8, AD_CFG0 = 5'd9, AD_CFG1 = 5'd10, AD_VSW = 5'd11,
                         AD_HSW = 5'd12;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_req = 1'b0, reg_wr = 1'b0;
  logic [4:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        reg_ready;
  logic [15:0] bus_wdata, bus_rdata;
  logic        bus_dc, bus_wr_n, bus_rd_n, frame_done;
  logic [1:0]  bus_cs_n;

  int n_tests = 0, n_fail = 0;
  int nlog = 0, nrd = 0, nframe = 0;
  logic [1:0]  lcs [8];
  logic        ldc [8];
  logic [15:0] lw  [8];

  always #4 clk = ~clk;

  // chip model: chip 0 answers 0xA00x, chip 1 answers 0xB00x, x = select line
  assign bus_rdata = !bus_rd_n ? (!bus_cs_n[0] ? {15'h5000, bus_dc} : {15'h5800, bus_dc}) : 16'h0;

  fbbus_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .reg_req(reg_req), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .reg_ready(reg_ready),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_dc(bus_dc), .bus_cs_n(bus_cs_n),
    .bus_wr_n(bus_wr_n), .bus_rd_n(bus_rd_n), .frame_done(frame_done)
  );

  always @(negedge clk) begin
    if (!bus_wr_n) begin
      if (nlog < 8) begin
        lcs[nlog] = bus_cs_n;
        ldc[nlog] = bus_dc;
        lw[nlog]  = bus_wdata;
      end
      nlog++;
    end
    if (!bus_rd_n) nrd++;
    if (frame_done) nframe++;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic acc(input logic wr, input logic [4:0] a, input logic [31:0] d,
                     output logic [31:0] rd, output int waits);
    @(negedge clk);
    reg_req = 1'b1; reg_wr = wr; reg_addr = a; reg_wdata = d;
    waits = 0;
    rd = '0;
    forever begin
      #1;
      if (reg_ready) begin
        rd = reg_rdata;
        @(posedge clk);
        #1;
        reg_req = 1'b0;
        break;
      end
      waits++;
      if (waits > 50) begin
        reg_req = 1'b0;
        break;
      end
      @(negedge clk);
    end
  endtask

  task automatic wreg(input logic [4:0] a, input logic [31:0] d);
    logic [31:0] rd; int w;
    acc(1'b1, a, d, rd, w);
  endtask

  task automatic rreg(input logic [4:0] a, output logic [31:0] rd);
    int w;
    acc(1'b0, a, 32'h0, rd, w);
  endtask

  // stimulus table: control value, address, word, bus cycles, cs_n, select, low word, high word
  localparam int NV = 6;
  localparam logic [3:0]  V_CTRL [NV] = '{4'h5, 4'h9, 4'hD, 4'h4, 4'hC, 4'h1};
  localparam logic [4:0]  V_ADDR [NV] = '{5'd4, 5'd5, 5'd4, 5'd6, 5'd6, 5'd6};
  localparam logic [31:0] V_WORD [NV] = '{32'hDEAD1234, 32'h00005A5A, 32'h000000C3,
                                          32'hBEEFCAFE, 32'h11112222, 32'h33334444};
  localparam int          V_NCYC [NV] = '{1, 1, 1, 2, 2, 0};
  localparam logic [1:0]  V_CS   [NV] = '{2'b10, 2'b01, 2'b00, 2'b10, 2'b00, 2'b11};
  localparam logic        V_DC   [NV] = '{1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1};
  localparam logic [15:0] V_W0   [NV] = '{16'h1234, 16'h5A5A, 16'h00C3, 16'hCAFE, 16'h2222, 16'h0};
  localparam logic [15:0] V_W1   [NV] = '{16'h0, 16'h0, 16'h0, 16'hBEEF, 16'h1111, 16'h0};

  initial begin
    #2_000_000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    int w, f0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 / R10 reset values
    rreg(AD_STAT, rd); chk("R1 R10 status after reset", rd, 32'h1);
    rreg(AD_CTRL, rd); chk("R1 control after reset", rd, 32'h2);
    rreg(AD_CFG0, rd); chk("R1 cfg0 after reset", rd, 32'h00310000);
    rreg(AD_CFG1, rd); chk("R1 cfg1 after reset", rd, 32'h00310000);
    rreg(AD_PIX, rd);  chk("R1 pixel counter after reset", rd, 32'h0);

    // R3 R4 R6 table walk
    for (int i = 0; i < NV; i++) begin
      wreg(AD_CTRL, {28'h0, V_CTRL[i]});
      nlog = 0;
      acc(1'b1, V_ADDR[i], V_WORD[i], rd, w);
      @(negedge clk);
      chk("R6 wait cycles", w, V_NCYC[i] + 1);
      chk("R6 bus cycle count", nlog, V_NCYC[i]);
      if (V_NCYC[i] > 0) begin
        chk("R3 chip selects", {30'h0, lcs[0]}, {30'h0, V_CS[i]});
        chk("R3 select line", {31'h0, ldc[0]}, {31'h0, V_DC[i]});
        chk("R3 R4 first word", {16'h0, lw[0]}, {16'h0, V_W0[i]});
      end
      if (V_NCYC[i] > 1) begin
        chk("R4 second word", {16'h0, lw[1]}, {16'h0, V_W1[i]});
        chk("R4 second select", {31'h0, ldc[1]}, 32'h1);
      end
    end
    rreg(AD_PIX, rd); chk("R7 no wrap from zero", rd, 32'h0);

    // R2 field masks
    wreg(AD_CTRL, 32'hFFFFFFEF); rreg(AD_CTRL, rd); chk("R2 control width", rd, 32'hF);
    wreg(AD_SKIP, 32'hFFFFFFFF); rreg(AD_SKIP, rd); chk("R2 skip width", rd, 32'h7FF);
    wreg(AD_VSW, 32'hFFFFFFFF);  rreg(AD_VSW, rd);  chk("R2 vsync width", rd, 32'hFFFF);
    wreg(AD_HSW, 32'h12345678);  rreg(AD_HSW, rd);  chk("R2 hsync width", rd, 32'h5678);
    wreg(AD_CFG0, 32'hFFFFFFFF); rreg(AD_CFG0, rd); chk("R2 cfg mask", rd, 32'h003F1FFF);
    rreg(AD_STAT, rd); chk("R8 status unaffected", rd, 32'h1);

    // R5 reads
    wreg(AD_CTRL, 32'hD);
    nrd = 0;
    wreg(AD_RXD, 32'h0);
    rreg(AD_RXD, rd); chk("R5 data read from chip 0", rd, 32'hA001);
    rreg(AD_RXS, rd); chk("R5 buffer via status address", rd, 32'hA001);
    chk("R5 single read cycle", nrd, 1);
    wreg(AD_CTRL, 32'h9);
    wreg(AD_RXS, 32'h0);
    rreg(AD_RXD, rd); chk("R5 status read from chip 1", rd, 32'hB000);
    wreg(AD_CTRL, 32'h1);
    nrd = 0;
    acc(1'b1, AD_RXD, 32'h0, rd, w);
    chk("R6 untargeted read waits", w, 1);
    rreg(AD_RXS, rd); chk("R5 buffer kept with no target", rd, 32'hB000);
    chk("R5 no read cycle untargeted", nrd, 0);

    // R7 R8 R9 countdown transfer
    wreg(AD_CTRL, 32'h5);
    wreg(AD_PIX, 32'd3);
    f0 = nframe;
    wreg(AD_CTRL, 32'h15);
    rreg(AD_STAT, rd); chk("R8 R10 busy after trigger", rd, 32'h101);
    wreg(AD_DATA, 32'h0);
    rreg(AD_PIX, rd); chk("R7 decrement by data write", rd, 32'd2);
    wreg(AD_RXD, 32'h0);
    rreg(AD_PIX, rd); chk("R7 decrement by read", rd, 32'd1);
    rreg(AD_STAT, rd); chk("R9 still busy", rd, 32'h101);
    wreg(AD_DATA, 32'h0);
    @(negedge clk); @(negedge clk);
    rreg(AD_STAT, rd); chk("R9 busy clears at zero", rd, 32'h1);
    chk("R9 one frame pulse", nframe - f0, 1);
    wreg(AD_DATA, 32'h0);
    rreg(AD_PIX, rd); chk("R7 stays zero", rd, 32'h0);
    chk("R9 no extra pulse", nframe - f0, 1);

    // R8 blockers (cfg0 has bits 3:2 set from the mask test)
    wreg(AD_PIX, 32'd2);
    wreg(AD_CTRL, 32'h14); rreg(AD_STAT, rd); chk("R8 blocked by enable clear", rd, 32'h1);
    wreg(AD_CTRL, 32'h17); rreg(AD_STAT, rd); chk("R8 blocked by bypass", rd, 32'h1);
    wreg(AD_CFG1, 32'h0031000C);
    wreg(AD_CTRL, 32'h15); rreg(AD_STAT, rd); chk("R8 blocked by both cfg", rd, 32'h1);
    wreg(AD_CFG1, 32'h00310000);
    wreg(AD_CTRL, 32'h15); rreg(AD_STAT, rd); chk("R8 trigger allowed", rd, 32'h101);
    wreg(AD_PIX, 32'd5);
    f0 = nframe;
    wreg(AD_CTRL, 32'h15);
    @(negedge clk); @(negedge clk);
    chk("R8 retrigger while busy ignored", nframe - f0, 0);
    rreg(AD_PIX, rd); chk("R8 count kept on retrigger", rd, 32'd5);
    wreg(AD_PIX, 32'd1);
    wreg(AD_DATA, 32'h0);
    @(negedge clk); @(negedge clk);
    rreg(AD_STAT, rd); chk("R9 finished", rd, 32'h1);
    chk("R9 pulse on finish", nframe - f0, 1);

    // R9 trigger with zero count
    f0 = nframe;
    wreg(AD_CTRL, 32'h15);
    @(negedge clk); @(negedge clk);
    chk("R9 zero count completes at once", nframe - f0, 1);
    rreg(AD_STAT, rd); chk("R9 zero count no busy", rd, 32'h1);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule